// File: doc/BRIEF.md
# Latched Parallel Switch-Select Decoder

This block is the parallel-programming control path of a four-switch analog multiplexer. Switches sit on two common nodes: switch 0 joins input 1 to common A, switch 1 joins input 2 to common A, switch 2 joins input 3 to common B, and switch 3 joins input 4 to common B. A two-bit address and an active-high disable are captured by level-sensitive latches, which are open while the hold input is low. The latched values are then decoded into one enable per switch.

The pair-mode input is not latched and acts directly on the decode. When it is high, the block behaves as two 1-of-2 selectors that share address bit 0, and the upper address bit is ignored. When it is low, the block behaves as a single 1-of-4 selector. An asynchronous clear turns every switch off. It also forces the latches to their power-up contents, so no switch turns on again until a new value is latched. While the serial-mode input is high, the parallel path drives all enables low and leaves its latches untouched.

Top module: `pmux_par_ctrl`

## Requirements
- R1: While serMode is 1, swOn is 4'b0000, and the latches ignore addrIn and disableIn even with latchHold at 0. Returning serMode to 0 with latchHold at 1 shows the values held before serial mode.
- R2: While latchHold is 0 (serMode 0, clearIn 0), the latches are transparent, so swOn follows addrIn and disableIn with no clock.
- R3: While latchHold is 1, changes on addrIn and disableIn leave swOn unchanged.
- R4: pairMode is not latched. Toggling it while latchHold is 1 changes swOn at once, using the held address.
- R5: With pairMode 1 and latched disable 0, addrIn[1] is ignored. Held addr bit 0 = 0 gives swOn = 4'b0101 (switches 0 and 2). Bit 0 = 1 gives swOn = 4'b1010 (switches 1 and 3).
- R6: With pairMode 0 and latched disable 0, swOn is one-hot with bit index equal to the held address (00 gives bit 0, 11 gives bit 3).
- R7: A latched disable of 1 gives swOn = 4'b0000 in either mode.
- R8: clearIn at 1 gives swOn = 4'b0000 and sets the latches to address 00 with disable 1. After clearIn falls with latchHold at 1, swOn stays 4'b0000 until a new value is latched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| serMode | input | 1 | 1 hands control to the serial path; parallel path forces all off and freezes |
| pairMode | input | 1 | 1 selects dual 1-of-2 operation, 0 selects 1-of-4; not latched |
| latchHold | input | 1 | 0 makes the latches transparent, 1 holds them |
| clearIn | input | 1 | Asynchronous clear, active high |
| disableIn | input | 1 | Switch disable, active high, latched |
| addrIn | input | 2 | Switch address, latched |
| swOn | output | 4 | Per-switch enable, bit i for switch i |

## Verification
The hardest case to reach from the ports is a latch that must keep an old value while its data inputs move. This happens in two places: with the hold input high, and during serial mode with the hold input low. The stimulus first latches a known address. It then moves the address and disable inputs in each of these conditions, and reopens the view with hold high, so that any leak would show on swOn. Random sequences also mix clears with hold high, which exercises the path where the cleared contents must persist after the clear is released.

// File: rtl/pmux_pkg.sv
package pmux_pkg;
  // Strobes from the control to the latch/decode datapath
  typedef struct packed {
    logic openLatch;   // latches transparent
    logic clearLatch;  // force power-up contents
    logic forceOff;    // all switch enables low
  } pmux_strobe_t;
endpackage

// File: rtl/pmux_ctrl.sv
module pmux_ctrl
  import pmux_pkg::*;
(
  input  logic         serMode,
  input  logic         latchHold,
  input  logic         clearIn,
  output pmux_strobe_t strb
);
  always_comb begin
    strb.clearLatch = clearIn;
    strb.openLatch  = !serMode && !latchHold && !clearIn;
    strb.forceOff   = serMode || clearIn;
  end

  always_comb begin
    // R1
    if (serMode) begin
      ser_freeze_chk: assert (!strb.openLatch && strb.forceOff);
    end
  end
endmodule

// File: rtl/pmux_latch.sv
module pmux_latch #(
  parameter int ADDR_W = 2
) (
  input  logic              openLatch,
  input  logic              clearLatch,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              disableIn,
  output logic [ADDR_W-1:0] heldAddr,
  output logic              heldDis
);
  always_latch begin
    if (clearLatch) begin
      heldAddr <= '0;
      heldDis  <= 1'b1;
    end else if (openLatch) begin
      heldAddr <= addrIn;
      heldDis  <= disableIn;
    end
  end

  always_comb begin
    // R8
    if (clearLatch) begin
      clear_state_chk: assert (heldAddr == '0 && heldDis);
    end
  end
endmodule

// File: rtl/pmux_decode.sv
module pmux_decode #(
  parameter int NUM_SW = 4,
  parameter int ADDR_W = 2
) (
  input  logic              forceOff,
  input  logic              pairMode,
  input  logic [ADDR_W-1:0] heldAddr,
  input  logic              heldDis,
  output logic [NUM_SW-1:0] swOn
);
  localparam int HALF = NUM_SW / 2;

  logic offAll;
  assign offAll = forceOff || heldDis;

  for (genvar i = 0; i < NUM_SW; i++) begin : g_sw
    localparam logic [ADDR_W-1:0] QIDX = ADDR_W'(i);
    localparam logic [ADDR_W-2:0] DIDX = (ADDR_W-1)'(i % HALF);
    assign swOn[i] = !offAll &&
      (pairMode ? (heldAddr[ADDR_W-2:0] == DIDX) : (heldAddr == QIDX));
  end

  always_comb begin
    // R6
    if (!offAll && !pairMode) begin
      quad_onehot_chk: assert ($onehot(swOn));
    end
    // R5
    if (!offAll && pairMode) begin
      pair_count_chk: assert ($countones(swOn) == 2);
    end
    // R7
    if (heldDis) begin
      dis_off_chk: assert (swOn == '0);
    end
  end
endmodule

// File: rtl/pmux_par_ctrl.sv
module pmux_par_ctrl
  import pmux_pkg::*;
#(
  parameter int NUM_SW = 4,
  localparam int ADDR_W = $clog2(NUM_SW)
) (
  input  logic              serMode,
  input  logic              pairMode,
  input  logic              latchHold,
  input  logic              clearIn,
  input  logic              disableIn,
  input  logic [ADDR_W-1:0] addrIn,
  output logic [NUM_SW-1:0] swOn
);
  pmux_strobe_t      strb;
  logic [ADDR_W-1:0] heldAddr;
  logic              heldDis;

  pmux_ctrl ctrl_i (
    .serMode   (serMode),
    .latchHold (latchHold),
    .clearIn   (clearIn),
    .strb      (strb)
  );

  pmux_latch #(.ADDR_W(ADDR_W)) latch_i (
    .openLatch  (strb.openLatch),
    .clearLatch (strb.clearLatch),
    .addrIn     (addrIn),
    .disableIn  (disableIn),
    .heldAddr   (heldAddr),
    .heldDis    (heldDis)
  );

  pmux_decode #(.NUM_SW(NUM_SW), .ADDR_W(ADDR_W)) decode_i (
    .forceOff (strb.forceOff),
    .pairMode (pairMode),
    .heldAddr (heldAddr),
    .heldDis  (heldDis),
    .swOn     (swOn)
  );

  always_comb begin
    // R1
    if (serMode) begin
      ser_off_chk: assert (swOn == '0);
    end
    // R8
    if (clearIn) begin
      clear_off_chk: assert (swOn == '0);
    end
  end
endmodule

// File: tb/pmux_par_ctrl_tb.sv
module pmux_par_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic       serMode, pairMode, latchHold, clearIn, disableIn;
  logic [1:0] addrIn;
  logic [3:0] swOn;

  int testCnt = 0;
  int failCnt = 0;

  logic [1:0] mAddr;
  logic       mDis;

  pmux_par_ctrl dut_i (
    .serMode   (serMode),
    .pairMode  (pairMode),
    .latchHold (latchHold),
    .clearIn   (clearIn),
    .disableIn (disableIn),
    .addrIn    (addrIn),
    .swOn      (swOn)
  );

  function automatic logic [3:0] expSw(logic ser, logic clr, logic pair,
                                       logic [1:0] a, logic dis);
    if (ser || clr || dis) return 4'b0000;
    if (pair) return a[0] ? 4'b1010 : 4'b0101;
    return 4'b0001 << a;
  endfunction

  task automatic apply(logic ser, logic pair, logic hold, logic clr,
                       logic dis, logic [1:0] a);
    @(negedge clk);
    serMode = ser; pairMode = pair; latchHold = hold;
    clearIn = clr; disableIn = dis; addrIn = a;
    if (clr) begin
      mAddr = 2'b00; mDis = 1'b1;
    end else if (!ser && !hold) begin
      mAddr = a; mDis = dis;
    end
    #(CLK_PERIOD/4);
  endtask

  task automatic check(string tag);
    logic [3:0] e;
    e = expSw(serMode, clearIn, pairMode, mAddr, mDis);
    testCnt++;
    if (swOn !== e) begin
      failCnt++;
      $display("FAIL %s: swOn got %b expected %b", tag, swOn, e);
    end
  endtask

  task automatic checkVal(string tag, logic [3:0] e);
    testCnt++;
    if (swOn !== e) begin
      failCnt++;
      $display("FAIL %s: swOn got %b expected %b", tag, swOn, e);
    end
  endtask

  initial begin
    int cyc = 0;
    while (cyc < WATCHDOG) begin
      @(posedge clk);
      cyc++;
    end
    failCnt++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    mAddr = 2'b00; mDis = 1'b1;
    // R8 reset state
    apply(0, 0, 1, 1, 0, 2'b10); checkVal("R8 clear", 4'b0000);
    apply(0, 0, 1, 0, 0, 2'b10); checkVal("R8 release held off", 4'b0000);
    // R2 / R6 transparent 1-of-4
    for (int a = 0; a < 4; a++) begin
      apply(0, 0, 0, 0, 0, 2'(a)); checkVal("R6 quad decode", 4'b0001 << a);
    end
    apply(0, 0, 0, 0, 0, 2'b01); checkVal("R2 transparent", 4'b0010);
    // R3 hold
    apply(0, 0, 1, 0, 0, 2'b01);
    apply(0, 0, 1, 0, 1, 2'b11); checkVal("R3 hold addr/dis", 4'b0010);
    // R4 pair toggle while held
    apply(0, 1, 1, 0, 1, 2'b00); checkVal("R4 pair immediate", 4'b1010);
    apply(0, 0, 1, 0, 1, 2'b00); checkVal("R4 back to quad", 4'b0010);
    // R5 upper bit ignored
    apply(0, 1, 0, 0, 0, 2'b00); checkVal("R5 a0=0", 4'b0101);
    apply(0, 1, 0, 0, 0, 2'b10); checkVal("R5 a1 ignored", 4'b0101);
    apply(0, 1, 0, 0, 0, 2'b11); checkVal("R5 a0=1", 4'b1010);
    // R7 disable
    apply(0, 1, 0, 0, 1, 2'b11); checkVal("R7 disable pair", 4'b0000);
    apply(0, 0, 0, 0, 1, 2'b11); checkVal("R7 disable quad", 4'b0000);
    // R1 serial mode freezes latches
    apply(0, 0, 0, 0, 0, 2'b10);
    apply(1, 0, 0, 0, 0, 2'b10); checkVal("R1 serial off", 4'b0000);
    apply(1, 0, 0, 0, 0, 2'b01); checkVal("R1 serial off moved", 4'b0000);
    apply(0, 0, 1, 0, 1, 2'b11); checkVal("R1 latch untouched", 4'b0100);
    // Random mix
    for (int i = 0; i < 400; i++) begin
      int r;
      r = int'($urandom_range(0, 99));
      apply(r < 8, 1'($urandom), r >= 8 && r < 50, r >= 95,
            ($urandom_range(0, 3) == 0), 2'($urandom));
      check("RND R2 R3 R5 R6");
    end
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule